// File: doc/BRIEF.md
# Dual-Channel PCM Time-Slot Port

This block carries 8-bit voice samples for two channels over a pair of TDM serial highways. A single-cycle frame-sync pulse, sampled on the rising edge of the PCM bit clock, starts each 125 µs frame. The block counts bit clocks from that pulse and derives a slot number and a bit-within-slot position from the count. Each channel has its own configuration: a slot number, the highway it transmits on and the highway it receives from. Highway 0 is called A and highway 1 is called B.

In its slot, a channel sends its transmit sample on the chosen highway, most significant bit first. In the same slot it assembles eight received bits into its receive sample register. The transmit pins are not tri-stated inside the block. Each highway instead has a data output and a drive-enable output, and the pad ring builds the tri-state buffer from them. Each highway also has an open-drain, active-low slot strobe. The block exposes it as a pull-down enable, so a value of 1 means the pad pulls the line low.

On the core side the block offers parallel transmit sample inputs, receive sample outputs and a one-cycle receive-valid pulse for each channel.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is asserted, and at once when reset is asserted in the middle of a slot, `hwy_oe` and `hwy_strb_pd` are 0. `rx_valid` and `conflict` are 0 and `rx_sample` is 0.
- R2: The rising edge that samples `fs` high starts bit period 0. Bit period k starts at the k-th rising edge after it. Slot n covers bit periods 8n to 8n+7. Before the first `fs` after reset, nothing is driven.
- R3: In its slot, channel c drives `tx_sample[c]` on highway `tx_hwy_sel[c]` (0 = A, 1 = B), bit 7 in bit period 0 and bit 0 in bit period 7. The byte is taken at the slot's first rising edge, so later changes to `tx_sample` within the slot have no effect.
- R4: `hwy_oe[h]` and `hwy_strb_pd[h]` are 1 exactly in the bit periods in which highway h carries a channel's bit, and 0 at all other times.
- R5: Receive bits are sampled on the falling clock edge from highway `rx_hwy_sel[c]`. At the rising edge that ends the slot's 8th bit, `rx_sample[c]` takes the byte, first-received bit in bit 7, and `rx_valid[c]` is 1 for that one cycle. At all other times `rx_sample[c]` holds its value.
- R6: If both channels transmit on the same highway in the same slot, channel 0 drives and channel 1 is suppressed. `conflict` is 1 from the first rising edge after such a configuration is applied, and 0 otherwise.
- R7: A channel whose slot is never reached before the next `fs` transmits nothing and captures nothing. The bit count stops at 2^SLOT_W × 8 bit periods until the next `fs`.
- R8: While `active` is 0, nothing is driven on either highway and no byte is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs | input | 1 | Frame sync, one bit clock wide |
| active | input | 1 | 1 = operate, 0 = inactive (highways released) |
| tx_hwy_sel | input | NCH | Transmit highway per channel (0 = A, 1 = B) |
| rx_hwy_sel | input | NCH | Receive highway per channel (0 = A, 1 = B) |
| slot_sel | input | NCH×SLOT_W | Slot number per channel |
| tx_sample | input | NCH×8 | Transmit byte per channel |
| rx_sample | output | NCH×8 | Last received byte per channel |
| rx_valid | output | NCH | One-cycle pulse when rx_sample is updated |
| hwy_rx | input | 2 | Receive highway inputs, bit 0 = A, bit 1 = B |
| hwy_tx | output | 2 | Transmit highway data, bit 0 = A, bit 1 = B |
| hwy_oe | output | 2 | Transmit pad drive enable per highway |
| hwy_strb_pd | output | 2 | Slot strobe pull-down enable per highway |
| conflict | output | 1 | Both channels configured for the same highway and slot |

## Verification
Two channels can compete for the same highway in the same bit period. The bench provokes this with a vector that places both channels on highway A in slot 4, with different transmit bytes. It then checks, bit by bit, that the highway carries channel 0's byte and that `conflict` is 1. Both channels also capture in that same slot, so their `rx_valid` pulses fall in the same cycle. Each channel's received byte and pulse count are judged separately.

// File: rtl/pcm_tsp_pkg.sv
package pcm_tsp_pkg;
  localparam int NHWY     = 2;
  localparam int BYTE_W   = 8;
  localparam int BITSEL_W = 3;

  typedef enum logic {HWY_A = 1'b0, HWY_B = 1'b1} hwy_e;
endpackage

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int SLOT_W = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs,
  output logic [SLOT_W+2:0]   cnt_nx,
  output logic                run_nx,
  output logic [SLOT_W+2:0]   cnt_q,
  output logic                run_q
);
  localparam int BIT_W = SLOT_W + 3;
  localparam logic [BIT_W-1:0] LAST = '1;

  always_comb begin
    cnt_nx = cnt_q;
    run_nx = run_q;
    if (fs) begin
      cnt_nx = '0;
      run_nx = 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_nx = 1'b0;
      else               cnt_nx = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      run_q <= run_nx;
    end
  end
endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic [NCH-1:0] bits,
  output logic           d_q,
  output logic           oe_q,
  output logic           pd_q
);
  logic sel_any;
  logic bit_sel;

  // lowest channel index wins the highway
  always_comb begin
    sel_any = |hit;
    bit_sel = 1'b0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (hit[c]) bit_sel = bits[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
      pd_q <= 1'b0;
    end else begin
      oe_q <= sel_any;
      pd_q <= sel_any;
      if (sel_any) d_q <= bit_sel;
    end
  end
endmodule

// File: rtl/pcm_rx_chan.sv
module pcm_rx_chan (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       last,
  input  logic       smp,
  output logic [7:0] data_q,
  output logic       vld_q
);
  logic [6:0] sh_q, sh_nx;
  logic [7:0] data_nx;
  logic       vld_nx;

  always_comb begin
    sh_nx   = sh_q;
    data_nx = data_q;
    vld_nx  = 1'b0;
    if (take) begin
      sh_nx = {sh_q[5:0], smp};
      if (last) begin
        data_nx = {sh_q, smp};
        vld_nx  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sh_q   <= sh_nx;
      data_q <= data_nx;
      vld_q  <= vld_nx;
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
  import pcm_tsp_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int SLOT_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       fs,
  input  logic                       active,
  input  logic [NCH-1:0]             tx_hwy_sel,
  input  logic [NCH-1:0]             rx_hwy_sel,
  input  logic [NCH-1:0][SLOT_W-1:0] slot_sel,
  input  logic [NCH-1:0][7:0]        tx_sample,
  output logic [NCH-1:0][7:0]        rx_sample,
  output logic [NCH-1:0]             rx_valid,
  input  logic [1:0]                 hwy_rx,
  output logic [1:0]                 hwy_tx,
  output logic [1:0]                 hwy_oe,
  output logic [1:0]                 hwy_strb_pd,
  output logic                       conflict
);
  localparam int BIT_W = SLOT_W + BITSEL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_s_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic [BIT_W-1:0] cnt_nx, cnt_q;
  logic             run_nx, run_q;

  pcm_frame_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_n(rst_s_q), .fs(fs),
    .cnt_nx(cnt_nx), .run_nx(run_nx), .cnt_q(cnt_q), .run_q(run_q)
  );

  logic [SLOT_W-1:0]   slot_nx, slot_q;
  logic [BITSEL_W-1:0] bit_nx, bit_q;
  assign slot_nx = cnt_nx[BIT_W-1:BITSEL_W];
  assign bit_nx  = cnt_nx[BITSEL_W-1:0];
  assign slot_q  = cnt_q[BIT_W-1:BITSEL_W];
  assign bit_q   = cnt_q[BITSEL_W-1:0];

  // receive lines sampled mid-bit on the falling edge
  logic [1:0] smp_q;
  always_ff @(negedge clk or negedge rst_s_q) begin
    if (!rst_s_q) smp_q <= '0;
    else          smp_q <= hwy_rx;
  end

  logic [NCH-1:0]            in_slot_nx, take, tx_bit;
  logic [NCH-1:0][7:0]       hold_q;
  logic [NHWY-1:0][NCH-1:0]  hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hold_en;
    assign in_slot_nx[c] = active && run_nx && (slot_nx == slot_sel[c]);
    assign hold_en       = in_slot_nx[c] && (bit_nx == '0);
    assign tx_bit[c]     = (bit_nx == '0) ? tx_sample[c][7] : hold_q[c][~bit_nx];
    assign take[c]       = active && run_q && (slot_q == slot_sel[c]);

    always_ff @(posedge clk or negedge rst_s_q) begin
      if (!rst_s_q)     hold_q[c] <= '0;
      else if (hold_en) hold_q[c] <= tx_sample[c];
    end

    pcm_rx_chan u_rx (
      .clk(clk), .rst_n(rst_s_q), .take(take[c]), .last(bit_q == '1),
      .smp(smp_q[rx_hwy_sel[c]]), .data_q(rx_sample[c]), .vld_q(rx_valid[c])
    );
  end

  for (genvar h = 0; h < NHWY; h++) begin : g_hwy
    for (genvar c = 0; c < NCH; c++) begin : g_hit
      assign hit[h][c] = in_slot_nx[c] && (tx_hwy_sel[c] == 1'(h));
    end
    pcm_tx_lane #(.NCH(NCH)) u_lane (
      .clk(clk), .rst_n(rst_s_q), .hit(hit[h]), .bits(tx_bit),
      .d_q(hwy_tx[h]), .oe_q(hwy_oe[h]), .pd_q(hwy_strb_pd[h])
    );
  end

  logic conf_nx;
  always_comb begin
    conf_nx = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      for (int j = i + 1; j < NCH; j++) begin
        if (tx_hwy_sel[i] == tx_hwy_sel[j] && slot_sel[i] == slot_sel[j]) conf_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) conflict <= 1'b0;
    else          conflict <= conf_nx;
  end
endmodule

// File: rtl/pcm_slot_port_chk.sv
module pcm_slot_port_chk #(
  parameter int NCH = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fs,
  input logic                active,
  input logic [1:0]          hwy_oe,
  input logic [1:0]          hwy_strb_pd,
  input logic [NCH-1:0]      rx_valid,
  input logic [NCH-1:0][7:0] rx_sample
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  seen_q <= 1'b0;
    else if (fs) seen_q <= 1'b1;
  end

  // R2
  pre_fs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hwy_oe != 2'b00) |-> seen_q);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (hwy_oe == 2'b00));

  // R4
  strobe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hwy_strb_pd == hwy_oe);

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid != '0) |=> ((rx_valid & $past(rx_valid)) == '0));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R5
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid[c] |-> $stable(rx_sample[c]));
  end
endmodule

bind pcm_slot_port pcm_slot_port_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs(fs), .active(active), .hwy_oe(hwy_oe),
  .hwy_strb_pd(hwy_strb_pd), .rx_valid(rx_valid), .rx_sample(rx_sample)
);

// File: tb/pcm_slot_port_test.sv
`timescale 1ns/1ps
module pcm_slot_port_test;
  localparam int NCH = 2;
  localparam int SW  = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rst_n, fs, active;
  logic [NCH-1:0]         tx_hwy_sel, rx_hwy_sel;
  logic [NCH-1:0][SW-1:0] slot_sel;
  logic [NCH-1:0][7:0]    tx_sample, rx_sample;
  logic [NCH-1:0]         rx_valid;
  logic [1:0]             hwy_rx, hwy_tx, hwy_oe, hwy_strb_pd;
  logic                   conflict;

  pcm_slot_port #(.NCH(NCH), .SLOT_W(SW)) uut (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic       act;
    logic [1:0] txs;
    logic [1:0] rxs;
    logic [6:0] s0;
    logic [6:0] s1;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] len;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b10, 2'b10, 7'd2,   7'd5,  8'hA5, 8'h3C, 8'd32},
    '{1'b1, 2'b00, 2'b01, 7'd0,   7'd31, 8'h81, 8'h7E, 8'd32},
    '{1'b1, 2'b00, 2'b10, 7'd4,   7'd4,  8'hC3, 8'h18, 8'd32},
    '{1'b1, 2'b11, 2'b11, 7'd9,   7'd20, 8'h55, 8'hAA, 8'd16},
    '{1'b0, 2'b01, 2'b00, 7'd3,   7'd6,  8'h66, 8'h99, 8'd16},
    '{1'b1, 2'b01, 2'b11, 7'd127, 7'd64, 8'hF0, 8'h0F, 8'd128}
  };

  function automatic logic [7:0] line_byte(int h, int s, int v);
    return 8'(s * 29 + v * 13 + h * 101 + 90);
  endfunction

  logic [NCH-1:0][7:0] rxe;

  task automatic apply_cfg(input vec_t vv);
    active        = vv.act;
    tx_hwy_sel    = vv.txs;
    rx_hwy_sel    = vv.rxs;
    slot_sel[0]   = vv.s0;
    slot_sel[1]   = vv.s1;
    tx_sample[0]  = vv.b0;
    tx_sample[1]  = vv.b1;
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fs = 1'b0;
    hwy_rx = 2'b00;
    apply_cfg(VECS[0]);
    repeat (3) @(posedge clk);
    #5;
    // R1 reset state
    chk(hwy_oe == 2'b00 && hwy_strb_pd == 2'b00, "R1", "oe/strobe in reset", {hwy_oe, hwy_strb_pd}, 0);
    chk(rx_valid == '0 && conflict == 1'b0, "R1", "valid/conflict in reset", {rx_valid, conflict}, 0);
    chk(rx_sample == '0, "R1", "rx_sample in reset", rx_sample, 0);
    rxe = '0;
    @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: nothing driven before first frame sync
    begin
      int drv = 0;
      slot_sel = '0;
      for (int i = 0; i < 40; i++) begin
        @(posedge clk);
        #5 if (hwy_oe != 2'b00 || hwy_strb_pd != 2'b00) drv++;
      end
      chk(drv == 0, "R2", "drive before fs", drv, 0);
    end

    for (int v = 0; v < NV; v++) begin
      vec_t vv;
      int len;
      int vcnt [NCH];
      logic [NCH-1:0][7:0] cur, lat;
      logic [NCH-1:0][SW-1:0] ss;
      vv = VECS[v];
      len = int'(vv.len);
      ss[0] = vv.s0;
      ss[1] = vv.s1;
      vcnt[0] = 0;
      vcnt[1] = 0;
      @(posedge clk);
      #2 apply_cfg(vv);
      fs = 1'b1;
      cur[0] = vv.b0;
      cur[1] = vv.b1;
      lat = cur;
      for (int k = 0; k <= len * 8; k++) begin
        int slot;
        int b;
        slot = k / 8;
        b = k % 8;
        @(posedge clk);
        if (b == 0) lat = cur;
        #2;
        fs = 1'b0;
        for (int h = 0; h < 2; h++) hwy_rx[h] = line_byte(h, slot, v)[7 - b];
        if (b == 3) begin
          cur = ~cur;
          tx_sample = cur;
        end
        #3;
        if (k == 0) begin
          logic ec;
          ec = (vv.txs[0] == vv.txs[1]) && (vv.s0 == vv.s1);
          // R6 conflict flag
          chk(conflict == ec, "R6", "conflict", conflict, ec);
        end
        for (int h = 0; h < 2; h++) begin
          int drv;
          drv = -1;
          for (int c = NCH - 1; c >= 0; c--) begin
            if (vv.act && slot < len && slot == int'(ss[c]) && int'(vv.txs[c]) == h) drv = c;
          end
          // R3 R4 R6 R7 R8 transmit path
          chk(hwy_oe[h] == (drv >= 0) && hwy_strb_pd[h] == (drv >= 0), "R4", "oe/strobe",
              {hwy_oe[h], hwy_strb_pd[h]}, (drv >= 0) ? 3 : 0);
          if (drv >= 0)
            chk(hwy_tx[h] == lat[drv][7 - b], (vv.s0 == vv.s1) ? "R6" : "R3", "tx bit",
                hwy_tx[h], lat[drv][7 - b]);
        end
        for (int c = 0; c < NCH; c++) vcnt[c] += int'(rx_valid[c]);
      end
      for (int c = 0; c < NCH; c++) begin
        bit cap;
        cap = vv.act && int'(ss[c]) < len;
        if (cap) rxe[c] = line_byte(int'(vv.rxs[c]), int'(ss[c]), v);
        // R5 capture, R7 out-of-frame slot, R8 inactive
        chk(vcnt[c] == (cap ? 1 : 0), cap ? "R5" : (vv.act ? "R7" : "R8"), "rx_valid pulses",
            vcnt[c], cap ? 1 : 0);
        chk(rx_sample[c] == rxe[c], cap ? "R5" : (vv.act ? "R7" : "R8"), "rx_sample",
            rx_sample[c], rxe[c]);
      end
    end

    // R1: reset asserted in the middle of a transmitting slot
    @(posedge clk);
    #2 apply_cfg(VECS[0]);
    fs = 1'b1;
    @(posedge clk);
    #2 fs = 1'b0;
    repeat (18) @(posedge clk);
    #5 chk(hwy_oe[0] == 1'b1, "R3", "slot 2 driving before reset", hwy_oe[0], 1);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #3 chk(hwy_oe == 2'b00 && hwy_strb_pd == 2'b00, "R1", "release on mid-slot reset",
           {hwy_oe, hwy_strb_pd}, 0);
    chk(rx_sample == '0 && conflict == 1'b0, "R1", "state after mid-slot reset",
        {rx_sample, conflict}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule